// File: doc/BRIEF.md
# Bus Ownership Arbiter with Refresh Reclaim

This block decides, one bus cycle at a time, whether a processor core or an external bus master owns the shared address and data buses. There are two ways to take the bus from the core. A bus request takes it at the end of the current bus cycle. A halt request takes it only at an instruction boundary, which the core marks with a strobe. Every change of owner inserts a dead cycle, so that two drivers never contend for the bus. A cycle-tick input marks the end of each bus cycle, and all state advances on that tick only.

An external master that keeps its request asserted gets a bounded window of bus cycles. When the window is used up, the core takes the bus back for one dead cycle and one refresh cycle. If the request is still asserted after that, the master is granted the bus again with a fresh window. A halt has no window and lasts until it is released.

The block reports the processor state on a two-bit code and drives the enables for the address bus and the data bus. It provides a qualifier that marks memory accesses as valid. It blocks the fast and normal interrupt requests while the core is off the bus. It keeps a non-maskable interrupt event latched until the core takes it.

Top module: `busarb_top`

## Requirements
- R1: After reset the state code is 00, both bus enables and the valid-access qualifier are high, the refresh strobe is low and no non-maskable event is pending.
- R2: The state code {ba, bs} reads 11 while the bus is granted or the core is halted. Otherwise it reads 10 while syncWait is high, 01 while vecFetch is high (syncWait takes precedence), and 00 in all other cases. ba is bit 1 of procState.
- R3: busReqN sampled low at a cycle tick makes the next bus cycle a granted one (code 11). Without a tick, the state does not change.
- R4: haltN low has effect only at a tick where instrEnd is high. The halt then lasts with no cycle limit and with no refresh until haltN returns high.
- R5: A bus-request grant lasts at most MAX_HOLD bus cycles, dead cycle included. Then come one reclaim cycle with ba low and the address bus off, and one refresh cycle with refreshCyc high and the address bus on. The request is granted again after that if busReqN is still low.
- R6: When busReqN is high at the end of a granted cycle, one reclaim cycle with ba low follows, then normal running. No refresh cycle is inserted, even if the window ran out in that same cycle.
- R7: addrEn is low while ba is high and during the bus cycle that follows one with ba high. dataEn is low exactly while ba is high.
- R8: validAccess is low in every bus cycle whose ba differs from the ba of the previous bus cycle, and high otherwise.
- R9: While the code is 11, irqOut and firqOut are held low whatever irqIn and firqIn are. Otherwise they follow those inputs.
- R10: A pulse on nmiEdge sets nmiPend from the next clock, in any state. nmiPend then stays high until a pulse on nmiTake. If both pulse together, nmiPend is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleTick | input | 1 | High in the last clock of each bus cycle |
| busReqN | input | 1 | Active-low bus request from the external master |
| haltN | input | 1 | Active-low halt request |
| instrEnd | input | 1 | Core marks the last bus cycle of an instruction |
| vecFetch | input | 1 | Core is fetching an interrupt or reset vector |
| syncWait | input | 1 | Core is waiting for a synchronisation input |
| irqIn | input | 1 | Normal interrupt request |
| firqIn | input | 1 | Fast interrupt request |
| nmiEdge | input | 1 | Detected non-maskable interrupt edge (pulse) |
| nmiTake | input | 1 | Core has started servicing the non-maskable interrupt |
| procState | output | 2 | State code {ba, bs} |
| addrEn | output | 1 | Address bus and R/W drive enable |
| dataEn | output | 1 | Data bus drive enable |
| validAccess | output | 1 | Access qualifier, low in cycles where ba changes |
| refreshCyc | output | 1 | Forced refresh cycle in progress |
| irqOut | output | 1 | Normal interrupt request passed on to the core |
| firqOut | output | 1 | Fast interrupt request passed on to the core |
| nmiPend | output | 1 | Latched non-maskable interrupt event |

## Verification
The hardest case to reach is a request that is withdrawn in exactly the cycle where the hold window runs out. In that cycle the release has to win over the refresh. A withdrawal in the reclaim or refresh cycle has to finish the pending refresh before the core runs. To reach these cases, the bench uses a window of four cycles and sweeps the request length over every value up to three full grant–reclaim–refresh periods. Each release then falls on every phase of the period, and the expected phase of every cycle is computed from the request length with modular arithmetic.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_GRANT   = 2'd1,
    ST_RECLAIM = 2'd2,
    ST_REFRESH = 2'd3
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic grantOn;
    logic refreshOn;
    logic cntLoad1;
    logic cntLoad2;
    logic cntInc;
  } arbStrobe_t;

  localparam logic [1:0] CODE_RUN   = 2'b00;
  localparam logic [1:0] CODE_VEC   = 2'b01;
  localparam logic [1:0] CODE_SYNC  = 2'b10;
  localparam logic [1:0] CODE_GRANT = 2'b11;

endpackage

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
  import busarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleTick,
  input  logic       busReqN,
  input  logic       haltN,
  input  logic       instrEnd,
  input  logic       holdDone,
  output arbStrobe_t strobe
);

  arbState_t state, stateNxt;
  logic haltMode, haltNxt;
  logic refreshDue, dueNxt;
  logic ld1, ld2, inc;

  always_comb begin
    stateNxt = state;
    haltNxt  = haltMode;
    dueNxt   = refreshDue;
    ld1      = 1'b0;
    ld2      = 1'b0;
    inc      = 1'b0;
    case (state)
      ST_RUN: begin
        if (!busReqN) begin
          stateNxt = ST_GRANT;
          haltNxt  = 1'b0;
          ld1      = 1'b1;
        end else if (!haltN && instrEnd) begin
          stateNxt = ST_GRANT;
          haltNxt  = 1'b1;
          ld1      = 1'b1;
        end
      end
      ST_GRANT: begin
        if (haltMode) begin
          if (haltN) begin
            if (!busReqN) begin
              haltNxt = 1'b0;   // hand over to the windowed request
              ld2     = 1'b1;
            end else begin
              stateNxt = ST_RECLAIM;
              dueNxt   = 1'b0;
            end
          end
        end else if (busReqN) begin
          stateNxt = ST_RECLAIM;  // release wins over window expiry
          dueNxt   = 1'b0;
        end else if (holdDone) begin
          stateNxt = ST_RECLAIM;
          dueNxt   = 1'b1;
        end else begin
          inc = 1'b1;
        end
      end
      ST_RECLAIM: begin
        stateNxt = refreshDue ? ST_REFRESH : ST_RUN;
        dueNxt   = 1'b0;
      end
      ST_REFRESH: begin
        if (!busReqN) begin
          stateNxt = ST_GRANT;
          haltNxt  = 1'b0;
          ld1      = 1'b1;
        end else begin
          stateNxt = ST_RUN;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RUN;
      haltMode   <= 1'b0;
      refreshDue <= 1'b0;
    end else if (cycleTick) begin
      state      <= stateNxt;
      haltMode   <= haltNxt;
      refreshDue <= dueNxt;
    end
  end

  always_comb begin
    strobe.grantOn   = (state == ST_GRANT);
    strobe.refreshOn = (state == ST_REFRESH);
    strobe.cntLoad1  = cycleTick && ld1;
    strobe.cntLoad2  = cycleTick && ld2;
    strobe.cntInc    = cycleTick && inc;
  end

endmodule

// File: rtl/busarb_dp.sv
module busarb_dp
  import busarb_pkg::*;
#(
  parameter int MAX_HOLD = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleTick,
  input  arbStrobe_t strobe,
  input  logic       vecFetch,
  input  logic       syncWait,
  input  logic       irqIn,
  input  logic       firqIn,
  input  logic       nmiEdge,
  input  logic       nmiTake,
  output logic [1:0] procState,
  output logic       addrEn,
  output logic       dataEn,
  output logic       validAccess,
  output logic       refreshCyc,
  output logic       irqOut,
  output logic       firqOut,
  output logic       nmiPend,
  output logic       holdDone
);

  localparam int CW = $clog2(MAX_HOLD + 1);

  logic [CW-1:0] holdCnt;
  logic          baPrev;
  logic          baNow;
  logic          nmiLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.cntLoad1) begin
      holdCnt <= CW'(1);
    end else if (strobe.cntLoad2) begin
      holdCnt <= CW'(2);
    end else if (strobe.cntInc) begin
      holdCnt <= holdCnt + CW'(1);
    end
  end

  assign holdDone = (holdCnt == CW'(MAX_HOLD));

  always_comb begin
    if (strobe.grantOn)        procState = CODE_GRANT;
    else if (strobe.refreshOn) procState = CODE_RUN;
    else if (syncWait)         procState = CODE_SYNC;
    else if (vecFetch)         procState = CODE_VEC;
    else                       procState = CODE_RUN;
  end

  assign baNow = procState[1];

  always_ff @(posedge clk) begin
    if (!rstN)          baPrev <= 1'b0;
    else if (cycleTick) baPrev <= baNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        nmiLatch <= 1'b0;
    else if (nmiEdge) nmiLatch <= 1'b1;
    else if (nmiTake) nmiLatch <= 1'b0;
  end

  assign addrEn      = !baNow && !baPrev;
  assign dataEn      = !baNow;
  assign validAccess = (baNow == baPrev);
  assign refreshCyc  = strobe.refreshOn;
  assign irqOut      = irqIn && !strobe.grantOn;
  assign firqOut     = firqIn && !strobe.grantOn;
  assign nmiPend     = nmiLatch;

endmodule

// File: rtl/busarb_top.sv
module busarb_top
  import busarb_pkg::*;
#(
  parameter int MAX_HOLD = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleTick,
  input  logic       busReqN,
  input  logic       haltN,
  input  logic       instrEnd,
  input  logic       vecFetch,
  input  logic       syncWait,
  input  logic       irqIn,
  input  logic       firqIn,
  input  logic       nmiEdge,
  input  logic       nmiTake,
  output logic [1:0] procState,
  output logic       addrEn,
  output logic       dataEn,
  output logic       validAccess,
  output logic       refreshCyc,
  output logic       irqOut,
  output logic       firqOut,
  output logic       nmiPend
);

  arbStrobe_t strobe;
  logic       holdDone;

  busarb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycleTick(cycleTick),
    .busReqN  (busReqN),
    .haltN    (haltN),
    .instrEnd (instrEnd),
    .holdDone (holdDone),
    .strobe   (strobe)
  );

  busarb_dp #(.MAX_HOLD(MAX_HOLD)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cycleTick  (cycleTick),
    .strobe     (strobe),
    .vecFetch   (vecFetch),
    .syncWait   (syncWait),
    .irqIn      (irqIn),
    .firqIn     (firqIn),
    .nmiEdge    (nmiEdge),
    .nmiTake    (nmiTake),
    .procState  (procState),
    .addrEn     (addrEn),
    .dataEn     (dataEn),
    .validAccess(validAccess),
    .refreshCyc (refreshCyc),
    .irqOut     (irqOut),
    .firqOut    (firqOut),
    .nmiPend    (nmiPend),
    .holdDone   (holdDone)
  );

endmodule

// File: rtl/busarb_checker.sv
module busarb_checker #(
  parameter int MAX_HOLD = 15
) (
  input logic       clk,
  input logic       rstN,
  input logic       cycleTick,
  input logic       haltN,
  input logic       nmiEdge,
  input logic [1:0] procState,
  input logic       addrEn,
  input logic       dataEn,
  input logic       refreshCyc,
  input logic       irqOut,
  input logic       firqOut,
  input logic       nmiPend
);

  localparam int KW = $clog2(MAX_HOLD + 2) + 1;
  logic [KW-1:0] grantRun;

  // consecutive granted bus cycles not covered by a halt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantRun <= '0;
    end else if (cycleTick) begin
      if (procState == 2'b11 && haltN) begin
        if (grantRun != {KW{1'b1}}) grantRun <= grantRun + KW'(1);
      end else begin
        grantRun <= '0;
      end
    end
  end

  assert_bus_off_in_grant_R7: assert property (@(posedge clk) disable iff (!rstN)
    (procState == 2'b11) |-> (!addrEn && !dataEn));

  assert_dead_after_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cycleTick && procState[1]) |=> !addrEn);

  assert_refresh_owned_R5: assert property (@(posedge clk) disable iff (!rstN)
    refreshCyc |-> (procState == 2'b00 && addrEn));

  assert_hold_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    grantRun <= KW'(MAX_HOLD));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    (procState == 2'b11) |-> (!irqOut && !firqOut));

  assert_nmi_latched_R10: assert property (@(posedge clk) disable iff (!rstN)
    nmiEdge |=> nmiPend);

endmodule

bind busarb_top busarb_checker #(.MAX_HOLD(MAX_HOLD)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cycleTick (cycleTick),
  .haltN     (haltN),
  .nmiEdge   (nmiEdge),
  .procState (procState),
  .addrEn    (addrEn),
  .dataEn    (dataEn),
  .refreshCyc(refreshCyc),
  .irqOut    (irqOut),
  .firqOut   (firqOut),
  .nmiPend   (nmiPend)
);

// File: tb/busarb_top_tb.sv
module busarb_top_tb;

  localparam int L = 4;       // hold window under test
  localparam int P = L + 2;   // grant window + reclaim + refresh

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleTick = 1'b1;
  logic busReqN = 1'b1;
  logic haltN = 1'b1;
  logic instrEnd = 1'b0;
  logic vecFetch = 1'b0;
  logic syncWait = 1'b0;
  logic irqIn = 1'b0;
  logic firqIn = 1'b0;
  logic nmiEdge = 1'b0;
  logic nmiTake = 1'b0;
  logic [1:0] procState;
  logic addrEn, dataEn, validAccess, refreshCyc, irqOut, firqOut, nmiPend;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  busarb_top #(.MAX_HOLD(L)) u_dut (
    .clk(clk), .rstN(rstN), .cycleTick(cycleTick), .busReqN(busReqN),
    .haltN(haltN), .instrEnd(instrEnd), .vecFetch(vecFetch), .syncWait(syncWait),
    .irqIn(irqIn), .firqIn(firqIn), .nmiEdge(nmiEdge), .nmiTake(nmiTake),
    .procState(procState), .addrEn(addrEn), .dataEn(dataEn),
    .validAccess(validAccess), .refreshCyc(refreshCyc), .irqOut(irqOut),
    .firqOut(firqOut), .nmiPend(nmiPend)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // go to the drive point of the next cycle
  task automatic nextCyc();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  // phase of cycle c for a request held low in cycles 0..T-1
  // 0 run, 1 grant, 2 reclaim, 3 refresh
  function automatic int expPhase(input int c, input int T);
    int p;
    if (c <= 0) return 0;
    if (c <= T) begin
      p = (c - 1) % P;
      return (p < L) ? 1 : ((p == L) ? 2 : 3);
    end
    p = (T - 1) % P;
    if (p < L)  return (c == T + 1) ? 2 : 0;
    if (p == L) return (c == T + 1) ? 3 : 0;
    return 0;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      nextCyc();
      busReqN = 1'b1; haltN = 1'b1; instrEnd = 1'b0; cycleTick = 1'b1;
      vecFetch = 1'b0; syncWait = 1'b0; nmiEdge = 1'b0; nmiTake = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    nextCyc();
    rstN = 1'b1;
    settle();
    // R1 reset state
    chk("R1 procState", procState, 0);
    chk("R1 addrEn", addrEn, 1);
    chk("R1 dataEn", dataEn, 1);
    chk("R1 validAccess", validAccess, 1);
    chk("R1 refreshCyc", refreshCyc, 0);
    chk("R1 nmiPend", nmiPend, 0);

    // R2 state codes from the core while it owns the bus
    nextCyc(); vecFetch = 1'b1; settle();
    chk("R2 vector code", procState, 1);
    chk("R7 addrEn on vector", addrEn, 1);
    nextCyc(); vecFetch = 1'b1; syncWait = 1'b1; settle();
    chk("R2 sync precedence", procState, 2);
    chk("R7 addrEn in sync", addrEn, 0);
    chk("R7 dataEn in sync", dataEn, 0);
    chk("R8 valid on ba rise", validAccess, 0);
    nextCyc(); vecFetch = 1'b0; syncWait = 1'b0; settle();
    chk("R2 running code", procState, 0);
    chk("R7 addrEn dead after sync", addrEn, 0);
    chk("R8 valid on ba fall", validAccess, 0);
    chk("R7 dataEn after sync", dataEn, 1);
    nextCyc(); settle();
    chk("R7 addrEn back", addrEn, 1);
    chk("R8 valid back", validAccess, 1);

    // R3 no tick, no change
    for (int i = 0; i < 3; i++) begin
      nextCyc(); cycleTick = 1'b0; busReqN = 1'b0; settle();
      chk("R3 hold without tick", procState, 0);
    end
    nextCyc(); cycleTick = 1'b1; settle();
    chk("R3 tick cycle still running", procState, 0);
    nextCyc(); settle();
    chk("R3 granted after tick", procState, 3);
    chk("R8 valid in dead grant", validAccess, 0);
    idle(5);

    // R4 halt only at instruction end, unlimited, no refresh
    for (int i = 0; i < 4; i++) begin
      nextCyc(); haltN = 1'b0; instrEnd = 1'b0; settle();
      chk("R4 halt waits for boundary", procState, 0);
    end
    nextCyc(); instrEnd = 1'b1; settle();
    chk("R4 boundary cycle running", procState, 0);
    for (int i = 0; i < 3 * L; i++) begin
      nextCyc(); instrEnd = 1'b0; irqIn = 1'b1; firqIn = 1'b1;
      nmiEdge = (i == 2); nmiTake = (i == 5) || (i == 8); settle();
      chk("R4 halted code", procState, 3);
      chk("R4 no refresh in halt", refreshCyc, 0);
      chk("R9 irq blocked", irqOut, 0);
      chk("R9 firq blocked", firqOut, 0);
      if (i == 8) nmiEdge = 1'b1;
      if (i >= 3 && i <= 5) chk("R10 nmi latched", nmiPend, 1);
      if (i == 6 || i == 7) chk("R10 nmi cleared", nmiPend, 0);
    end
    nextCyc(); nmiEdge = 1'b0; nmiTake = 1'b0; haltN = 1'b1; settle();
    chk("R10 set wins over take", nmiPend, 1);
    chk("R4 release cycle still halted", procState, 3);
    nextCyc(); nmiTake = 1'b1; settle();
    chk("R6 reclaim after halt", procState, 0);
    chk("R7 addrEn dead after halt", addrEn, 0);
    chk("R9 irq passes", irqOut, 1);
    chk("R9 firq passes", firqOut, 1);
    nextCyc(); nmiTake = 1'b0; settle();
    chk("R10 taken", nmiPend, 0);
    chk("R7 addrEn after halt", addrEn, 1);
    chk("R4 no refresh on halt exit", refreshCyc, 0);
    idle(3);

    // R5/R6 sweep of request length across three periods
    irqIn = 1'b1; firqIn = 1'b1;
    for (int T = 1; T <= 3 * P + 1; T++) begin
      int prevPh;
      prevPh = 0;
      for (int c = 0; c <= T + 4; c++) begin
        int ph;
        nextCyc();
        busReqN = (c < T) ? 1'b0 : 1'b1;
        settle();
        ph = expPhase(c, T);
        chk("R5 R6 state code", procState, (ph == 1) ? 3 : 0);
        chk("R5 refresh cycle", refreshCyc, (ph == 3) ? 1 : 0);
        chk("R7 addrEn", addrEn, (ph != 1 && prevPh != 1) ? 1 : 0);
        chk("R7 dataEn", dataEn, (ph != 1) ? 1 : 0);
        chk("R8 validAccess", validAccess, ((ph == 1) == (prevPh == 1)) ? 1 : 0);
        chk("R9 irqOut", irqOut, (ph != 1) ? 1 : 0);
        prevPh = ph;
      end
      idle(2);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule